// File: doc/BRIEF.md
# Serial Divider-Setting Loader for a Frequency Synthesizer

This block receives divider settings for a frequency synthesizer over a three-wire serial link (data, shift clock, latch enable) and holds them as parallel values for the counters. Each rising edge of the shift clock moves one data bit into an internal chain. The newest bit in the chain is a control flag. When the enable is high, the main and swallow divide latches follow the chain. If the flag is 1, the reference divide latch follows the chain as well.

The shift clock, data and enable are treated as slow asynchronous wires. They are synchronized into the single system clock domain, and the shift-clock edges are found internally. While the enable stays high the latches copy the chain on every system cycle, so they behave as transparent latches. While the enable is low the programmed values are frozen. The oldest stage of the chain drives a serial output directly, so several loaders can be daisy-chained.

Top module: `synth_serial_loader`

## Requirements
- R1: Each rising edge of `shift_clk_i` moves the chain one place toward its oldest stage and inserts `ser_data_i` as the newest bit. A field is sent most significant bit first. Without a rising edge the chain does not move.
- R2: `ser_out_o` is the oldest chain stage, without inversion. This is the bit entered 18 shift edges earlier. It is not affected by `latch_en_i`.
- R3: While `latch_en_i` is high and the newest chain bit (the control flag) is 1, `ref_div_o` takes the 14 bits entered just before the flag.
- R4: While `latch_en_i` is high and the control flag is 0, `ref_div_o` keeps its value.
- R5: While `latch_en_i` is high, whatever the control flag holds, the main and swallow outputs are loaded from the chain as follows:
  - `main_div_o` takes the 10 bits entered 18th to 9th most recently.
  - `swal_div_o` takes the 7 bits entered just before the control flag.
- R6: Bits shifted in while `latch_en_i` stays high reach the outputs without a new enable pulse, so the latches act as transparent latches.
- R7: While `latch_en_i` is low, all three divide outputs hold their values, even when bits are shifted.
- R8: After synchronous reset, the outputs and the chain take these values:
  - `ref_div_o` = 3
  - `main_div_o` = 16
  - `swal_div_o` = 0
  - the chain is all zeros, so `ser_out_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data_i | input | 1 | Serial data line |
| shift_clk_i | input | 1 | Shift clock; a rising edge shifts one bit |
| latch_en_i | input | 1 | Latch enable; latches are transparent while high |
| ref_div_o | output | 14 | Latched reference divide value |
| main_div_o | output | 10 | Latched main divide value |
| swal_div_o | output | 7 | Latched swallow value |
| ser_out_o | output | 1 | Oldest stage of the shift chain |

## Verification
A chain that drops or duplicates a shift edge shows up on `ser_out_o` after the next 18 edges. It also shows up in the divide outputs at the next enable pulse, about four system cycles after the enable rises. A wrongly decoded control flag shows up at the same point, as a reference value that was replaced when it should have been kept, or the reverse. A latch that leaks while the enable is low shows up on the first shift edge after the pulse. For that reason the bench checks the outputs after shifting with the enable low, as well as right after each pulse.

// File: rtl/synth_loader_pkg.sv
// Package: shared widths and reset defaults of the serial divider loader.
// Assumes: users take widths from here unless they override the top parameters.
package synth_loader_pkg;
    localparam int REF_W_DEF    = 14;
    localparam int MAIN_W_DEF   = 10;
    localparam int SWAL_W_DEF   = 7;
    localparam int RST_REF_DEF  = 3;
    localparam int RST_MAIN_DEF = 16;
    localparam int RST_SWAL_DEF = 0;
    localparam int SYNC_DEPTH   = 2;
endpackage

// File: rtl/loader_sync.sv
// Module: multi-bit input synchronizer. Each bit goes through its own flop stages.
// Assumes: the bits are slow, independent control wires that are held for many clocks.
module loader_sync #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [DEPTH];

    // Purpose: move the inputs through DEPTH flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[DEPTH-1];
endmodule

// File: rtl/loader_chain.sv
// Module: serial shift chain. The newest bit enters at index 0 and the oldest stage is LEN-1.
// Assumes: shift_en is a one-cycle pulse per shift-clock edge.
module loader_chain #(
    parameter int LEN = 18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] chain_q
);
    // Purpose: move the chain by one place on each shift pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        chain_q <= '0;
        else if (shift_en) chain_q <= {chain_q[LEN-2:0], din};
    end

    // R1: the chain never moves without a shift pulse
    a_r1_no_spurious_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/loader_latches.sv
// Module: divide-value latches that are transparent while en is high.
// The reference latch is also gated by the control flag.
// Assumes: en and ctrl come from the synchronized domain.
module loader_latches #(
    parameter int REF_W    = 14,
    parameter int MAIN_W   = 10,
    parameter int SWAL_W   = 7,
    parameter int RST_REF  = 3,
    parameter int RST_MAIN = 16,
    parameter int RST_SWAL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ctrl,
    input  logic [REF_W-1:0]  ref_field,
    input  logic [MAIN_W-1:0] main_field,
    input  logic [SWAL_W-1:0] swal_field,
    output logic [REF_W-1:0]  ref_q,
    output logic [MAIN_W-1:0] main_q,
    output logic [SWAL_W-1:0] swal_q
);
    // Purpose: reference latch, which follows the field only when the flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n)          ref_q <= REF_W'(RST_REF);
        else if (en && ctrl) ref_q <= ref_field;
    end

    // Purpose: main and swallow latch, which follows the fields whenever en is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= MAIN_W'(RST_MAIN);
            swal_q <= SWAL_W'(RST_SWAL);
        end else if (en) begin
            main_q <= main_field;
            swal_q <= swal_field;
        end
    end

    // R3: the flag set while enabled loads the reference field
    a_r3_ref_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctrl) |=> ref_q == $past(ref_field));
    // R4: the flag clear keeps the reference value
    a_r4_ref_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ctrl) |=> $stable(ref_q));
    // R5: enable loads main and swallow, whatever the flag holds
    a_r5_div_load: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (main_q == $past(main_field)) && (swal_q == $past(swal_field)));
    // R7: enable low freezes every output
    a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ref_q) && $stable(main_q) && $stable(swal_q));
endmodule

// File: rtl/synth_serial_loader.sv
// Module: top of the serial divider loader. It synchronizes the three serial wires,
// detects shift-clock edges, shifts the chain and drives the divide latches.
// Assumes: the serial wires are much slower than clk. Data is stable around the shift edge.
module synth_serial_loader
    import synth_loader_pkg::*;
#(
    parameter int REF_W    = REF_W_DEF,
    parameter int MAIN_W   = MAIN_W_DEF,
    parameter int SWAL_W   = SWAL_W_DEF,
    parameter int RST_REF  = RST_REF_DEF,
    parameter int RST_MAIN = RST_MAIN_DEF,
    parameter int RST_SWAL = RST_SWAL_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data_i,
    input  logic              shift_clk_i,
    input  logic              latch_en_i,
    output logic [REF_W-1:0]  ref_div_o,
    output logic [MAIN_W-1:0] main_div_o,
    output logic [SWAL_W-1:0] swal_div_o,
    output logic              ser_out_o
);
    localparam int DIV_W   = MAIN_W + SWAL_W;
    localparam int CHAIN_W = ((REF_W > DIV_W) ? REF_W : DIV_W) + 1;

    logic [2:0]         sync_w;
    logic               data_s, sclk_s, en_s;
    logic               sclk_d;
    logic               shift_pulse;
    logic [CHAIN_W-1:0] chain_w;

    loader_sync #(.W(3), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({latch_en_i, shift_clk_i, ser_data_i}),
        .sync_o  (sync_w)
    );
    assign {en_s, sclk_s, data_s} = sync_w;

    // Purpose: delay the synchronized shift clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign shift_pulse = sclk_s & ~sclk_d;

    loader_chain #(.LEN(CHAIN_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_pulse),
        .din      (data_s),
        .chain_q  (chain_w)
    );

    loader_latches #(
        .REF_W(REF_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W),
        .RST_REF(RST_REF), .RST_MAIN(RST_MAIN), .RST_SWAL(RST_SWAL)
    ) u_latches (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_s),
        .ctrl       (chain_w[0]),
        .ref_field  (chain_w[REF_W:1]),
        .main_field (chain_w[DIV_W:SWAL_W+1]),
        .swal_field (chain_w[SWAL_W:1]),
        .ref_q      (ref_div_o),
        .main_q     (main_div_o),
        .swal_q     (swal_div_o)
    );

    assign ser_out_o = chain_w[CHAIN_W-1];

    // R2: the serial output changes only after a detected shift edge
    a_r2_sdo_moves_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_pulse |=> $stable(ser_out_o));
    // R1: an edge pulse lasts one cycle
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse);
endmodule

// File: tb/sim_synth_serial_loader.sv
module sim_synth_serial_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdat = 1'b0, sclk = 1'b0, en = 1'b0;
    logic [13:0] ref_o;
    logic [9:0]  main_o;
    logic [6:0]  swal_o;
    logic        sdo;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Bench model, built from the requirements
    logic [17:0] m_chain;
    logic [13:0] e_ref;
    logic [9:0]  e_main;
    logic [6:0]  e_swal;

    always #4 clk = ~clk;   // 125 MHz

    synth_serial_loader u0 (
        .clk(clk), .rst_n(rst_n), .ser_data_i(sdat), .shift_clk_i(sclk),
        .latch_en_i(en), .ref_div_o(ref_o), .main_div_o(main_o),
        .swal_div_o(swal_o), .ser_out_o(sdo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply the enabled-latch rule of R3, R4 and R5 to the model
    function automatic void model_latch();
        if (m_chain[0]) e_ref = m_chain[14:1];
        e_main = m_chain[17:8];
        e_swal = m_chain[7:1];
    endfunction

    task automatic send_bit(input logic b);
        sdat = b;
        wait_clk(4);
        sclk = 1'b1;
        m_chain = {m_chain[16:0], b};
        wait_clk(4);
        sclk = 1'b0;
        wait_clk(4);
        if (en) model_latch();   // R6: transparent while enabled
    endtask

    task automatic send_word(input logic [31:0] v, input int nb);
        for (int i = nb - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic pulse_en();
        en = 1'b1;
        wait_clk(8);
        model_latch();
        en = 1'b0;
        wait_clk(8);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " ref"},  32'(ref_o),  32'(e_ref));
        chk({tag, " main"}, 32'(main_o), 32'(e_main));
        chk({tag, " swal"}, 32'(swal_o), 32'(e_swal));
        chk({tag, " sdo"},  32'(sdo),    32'(m_chain[17]));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_chain = '0; e_ref = 14'd3; e_main = 10'd16; e_swal = 7'd0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R8 reset");

        // R3: reference load, 14 bits followed by flag 1
        send_word(32'h2A5B, 14); send_bit(1'b1);
        pulse_en();
        check_all("R3 ref load");
        chk("R3 ref value", 32'(ref_o), 32'h2A5B);

        // R5 and R4: divider load, 10 + 7 bits followed by flag 0
        send_word(32'd777, 10); send_word(32'd99, 7); send_bit(1'b0);
        pulse_en();
        check_all("R5 div load");
        chk("R5 main value", 32'(main_o), 32'd777);
        chk("R4 ref kept", 32'(ref_o), 32'h2A5B);

        // R7: shifting with the enable low leaves the outputs alone
        send_word(32'h3FFFF, 18);
        check_all("R7 hold");
        chk("R7 main frozen", 32'(main_o), 32'd777);

        // R2: the serial output follows the oldest stage, both polarities
        send_word(32'h15555, 18);
        check_all("R2 sdo");
        send_bit(1'b0);
        check_all("R2 sdo");

        // R6: transparency while the enable is held high
        en = 1'b1;
        wait_clk(8);
        model_latch();
        send_word(32'd513, 10); send_word(32'd5, 7); send_bit(1'b0);
        check_all("R6 transparent");
        chk("R6 main live", 32'(main_o), 32'd513);
        en = 1'b0;
        wait_clk(8);

        // R1: random bit patterns and lengths, with occasional enable pulses
        for (int it = 0; it < 60; it++) begin
            int nb;
            nb = 1 + int'($urandom_range(30));
            for (int k = 0; k < nb; k++) send_bit(1'($urandom_range(1)));
            check_all("R1 random shift");
            if ($urandom_range(1)) begin
                pulse_en();
                check_all("R3 R4 R5 random latch");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule